// File: doc/BRIEF.md
# Bottleneck Call Dispatch Unit

This block decides, for every bottleneck call raised by a small core, whether the call runs on that core or is shipped to one of the large cores. Each small core has its own small associative table. The table maps a bottleneck identifier to the large core chosen to accelerate it, and a waiting-cycle tracker outside the block fills and prunes it through an update port. A call whose identifier is absent is told to run locally. A call whose identifier is present becomes a request carrying the identifier, target PC, stack pointer and requesting core number. The request is queued in the scheduling buffer of the chosen large core.

Each large core drains its own buffer in arrival order. When it finishes a shipped section, it reports the requester and the identifier on the return port. The block then answers the requester with a completion response. A small core may have only one request in flight. A second hit from that core, or a hit that finds its buffer full, is refused with a busy flag and falls back to local execution.

Top module: `bcd_dispatch_unit`

## Requirements
- R1: After reset no buffer head is valid, no local or completion response is raised, and every table is empty, so any call misses.
- R2: A call whose identifier is not in the caller's table raises localValid for exactly one cycle, in the cycle after the call, with localCore equal to the caller and localBusy low.
- R3: A hit call from a core with no request in flight raises no local response. In the second cycle after the call, the request (identifier, PC, stack pointer, caller) is visible in the buffer of the large core that the table names, at the head if that buffer was empty.
- R4: An update with updAccel=1 inserts the identifier into the named core's table, or repoints an existing entry to the new large core. An update with updAccel=0 removes the identifier, and removing an absent identifier changes nothing. Tables of different small cores are independent.
- R5: Inserting a new identifier into a full table (32 entries) evicts the entry whose last accelerate update is oldest. Re-accelerating an entry makes it the newest.
- R6: Each scheduling buffer is first-in first-out, and its head stays valid and unchanged until deqPop for that large core.
- R7: A hit call from a core that already has a request in flight, or whose target buffer is full, raises localValid and localBusy together, and nothing is enqueued.
- R8: A return whose retCore has a request in flight raises doneValid one cycle later with doneCore=retCore and doneId=retId, and frees that core to ship again. A return for a core with nothing in flight raises no completion.
- R9: deqPop on an empty buffer has no effect; the buffer stays empty and later requests still enter it normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| updValid | input | 1 | Table update strobe |
| updCore | input | CORE_W | Small core whose table is updated |
| updAccel | input | 1 | 1 inserts or repoints, 0 removes |
| updId | input | ID_W | Bottleneck identifier being updated |
| updLarge | input | LARGE_W | Large core assigned on insert |
| callValid | input | 1 | Bottleneck call strobe |
| callCore | input | CORE_W | Calling small core |
| callId | input | ID_W | Identifier of the call |
| callPc | input | PC_W | Target PC of the bottleneck code |
| callSp | input | SP_W | Caller stack pointer |
| localValid | output | 1 | Call must execute locally |
| localCore | output | CORE_W | Core that receives the local verdict |
| localBusy | output | 1 | Local verdict is a refusal of a hit |
| headValid | output | NUM_LARGE | Per large core: buffer holds a request |
| headId | output | NUM_LARGE x ID_W | Head request identifier per large core |
| headPc | output | NUM_LARGE x PC_W | Head request target PC per large core |
| headSp | output | NUM_LARGE x SP_W | Head request stack pointer per large core |
| headCore | output | NUM_LARGE x CORE_W | Head request caller per large core |
| deqPop | input | NUM_LARGE | Per large core: remove head request |
| retValid | input | 1 | Large core finished a shipped section |
| retCore | input | CORE_W | Requester named by the finished request |
| retId | input | ID_W | Identifier of the finished section |
| doneValid | output | 1 | Completion response strobe |
| doneCore | output | CORE_W | Core receiving the completion |
| doneId | output | ID_W | Identifier completed |

## Verification
A stale or corrupted table entry shows up on the next call to that identifier. Within one cycle the local verdict is wrong, and one cycle after that a request appears at the wrong buffer head, or fails to appear. A lost or stuck in-flight flag shows up as a wrong busy refusal on that core's next hit, or as a completion that is missing or spurious one cycle after a return. Buffer pointer damage changes the head fields on the cycle after an enqueue or pop. Evictions in a full table are exposed by calling both the expected victim and its neighbours.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  // control strobes handed from the control module to the datapath
  typedef struct packed {
    logic enqReq;    // push staged call into selected scheduling buffer
    logic runLocal;  // staged call executes on its own core
    logic refuse;    // staged hit refused (in flight or buffer full)
    logic retire;    // valid return: emit completion, free the requester
  } ctlStrobes_t;
endpackage

// File: rtl/bcd_index_table.sv
module bcd_index_table #(
  parameter int DEPTH   = 32,
  parameter int ID_W    = 12,
  parameter int LARGE_W = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               updValid,
  input  logic               updAccel,
  input  logic [ID_W-1:0]    updId,
  input  logic [LARGE_W-1:0] updLarge,
  input  logic [ID_W-1:0]    lookId,
  output logic               lookHit,
  output logic [LARGE_W-1:0] lookLarge
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = IDX_W + 1;

  logic [DEPTH-1:0]   entValid;
  logic [ID_W-1:0]    entId   [DEPTH];
  logic [LARGE_W-1:0] entDest [DEPTH];
  logic [IDX_W-1:0]   entRank [DEPTH];   // 0 = newest

  logic             updHit, freeFound;
  logic [IDX_W-1:0] updIdx, freeIdx, victimIdx, slotIdx;
  logic [CNT_W-1:0] fillCnt, bumpBelow;

  always_comb begin
    lookHit   = 1'b0;
    lookLarge = '0;
    updHit    = 1'b0;
    updIdx    = '0;
    freeFound = 1'b0;
    freeIdx   = '0;
    victimIdx = '0;
    fillCnt   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i]) begin
        fillCnt = fillCnt + 1'b1;
        if (entId[i] == lookId) begin
          lookHit   = 1'b1;
          lookLarge = entDest[i];
        end
        if (entId[i] == updId) begin
          updHit = 1'b1;
          updIdx = IDX_W'(i);
        end
        if (entRank[i] == IDX_W'(DEPTH - 1)) victimIdx = IDX_W'(i);
      end else if (!freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    if (updHit) begin
      slotIdx   = updIdx;
      bumpBelow = {1'b0, entRank[updIdx]};
    end else if (freeFound) begin
      slotIdx   = freeIdx;
      bumpBelow = fillCnt;
    end else begin
      slotIdx   = victimIdx;
      bumpBelow = CNT_W'(DEPTH - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entValid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entId[i]   <= '0;
        entDest[i] <= '0;
        entRank[i] <= '0;
      end
    end else if (updValid) begin
      if (updAccel) begin
        for (int i = 0; i < DEPTH; i++)
          if (entValid[i] && IDX_W'(i) != slotIdx && {1'b0, entRank[i]} < bumpBelow)
            entRank[i] <= entRank[i] + 1'b1;
        entValid[slotIdx] <= 1'b1;
        entId[slotIdx]    <= updId;
        entDest[slotIdx]  <= updLarge;
        entRank[slotIdx]  <= '0;
      end else if (updHit) begin
        for (int i = 0; i < DEPTH; i++)
          if (entValid[i] && entRank[i] > entRank[updIdx])
            entRank[i] <= entRank[i] - 1'b1;
        entValid[updIdx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_sched_fifo.sv
module bcd_sched_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic         headValid,
  output logic [W-1:0] headData,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign headValid = (count != '0);
  assign headData  = slots[rdPtr];
  assign doPush    = push && !full;
  assign doPop     = pop && headValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      if (doPush) begin
        slots[wrPtr] <= pushData;
        wrPtr        <= stepPtr(wrPtr);
      end
      if (doPop) rdPtr <= stepPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/bcd_datapath.sv
module bcd_datapath
  import bcd_pkg::*;
#(
  parameter int NUM_SMALL   = 4,
  parameter int NUM_LARGE   = 2,
  parameter int TABLE_DEPTH = 32,
  parameter int SB_DEPTH    = NUM_SMALL,
  parameter int ID_W        = 12,
  parameter int PC_W        = 16,
  parameter int SP_W        = 16,
  parameter int CORE_W      = (NUM_SMALL > 1) ? $clog2(NUM_SMALL) : 1,
  parameter int LARGE_W     = (NUM_LARGE > 1) ? $clog2(NUM_LARGE) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  ctlStrobes_t                       ctl,
  input  logic                              updValid,
  input  logic [CORE_W-1:0]                 updCore,
  input  logic                              updAccel,
  input  logic [ID_W-1:0]                   updId,
  input  logic [LARGE_W-1:0]                updLarge,
  input  logic                              callValid,
  input  logic [CORE_W-1:0]                 callCore,
  input  logic [ID_W-1:0]                   callId,
  input  logic [PC_W-1:0]                   callPc,
  input  logic [SP_W-1:0]                   callSp,
  input  logic [NUM_LARGE-1:0]              deqPop,
  input  logic [CORE_W-1:0]                 retCore,
  input  logic [ID_W-1:0]                   retId,
  output logic                              stgValid,
  output logic [CORE_W-1:0]                 stgCore,
  output logic                              lookHit,
  output logic                              selFull,
  output logic [NUM_LARGE-1:0]              headValid,
  output logic [NUM_LARGE-1:0][ID_W-1:0]    headId,
  output logic [NUM_LARGE-1:0][PC_W-1:0]    headPc,
  output logic [NUM_LARGE-1:0][SP_W-1:0]    headSp,
  output logic [NUM_LARGE-1:0][CORE_W-1:0]  headCore,
  output logic                              doneValid,
  output logic [CORE_W-1:0]                 doneCore,
  output logic [ID_W-1:0]                   doneId
);
  localparam int REQ_W   = ID_W + PC_W + SP_W + CORE_W;
  localparam int SP_LO   = CORE_W;
  localparam int PC_LO   = SP_LO + SP_W;
  localparam int ID_LO   = PC_LO + PC_W;

  logic [ID_W-1:0]    stgId;
  logic [PC_W-1:0]    stgPc;
  logic [SP_W-1:0]    stgSp;
  logic [NUM_SMALL-1:0] hitVec;
  logic [LARGE_W-1:0] largeVec [NUM_SMALL];
  logic [LARGE_W-1:0] selLarge;
  logic [NUM_LARGE-1:0] fullVec;
  logic [REQ_W-1:0]   reqWord;
  logic [REQ_W-1:0]   headWord [NUM_LARGE];

  // lookup stage: the call is registered, tables are searched next cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      stgValid <= 1'b0;
      stgCore  <= '0;
      stgId    <= '0;
      stgPc    <= '0;
      stgSp    <= '0;
    end else begin
      stgValid <= callValid;
      if (callValid) begin
        stgCore <= callCore;
        stgId   <= callId;
        stgPc   <= callPc;
        stgSp   <= callSp;
      end
    end
  end

  for (genvar s = 0; s < NUM_SMALL; s++) begin : g_table
    bcd_index_table #(.DEPTH(TABLE_DEPTH), .ID_W(ID_W), .LARGE_W(LARGE_W)) u_table (
      .clk(clk), .rst(rst),
      .updValid(updValid && updCore == CORE_W'(s)),
      .updAccel(updAccel), .updId(updId), .updLarge(updLarge),
      .lookId(stgId), .lookHit(hitVec[s]), .lookLarge(largeVec[s])
    );
  end

  assign lookHit  = hitVec[stgCore];
  assign selLarge = largeVec[stgCore];
  assign selFull  = fullVec[selLarge];
  assign reqWord  = {stgId, stgPc, stgSp, stgCore};

  for (genvar l = 0; l < NUM_LARGE; l++) begin : g_buffer
    bcd_sched_fifo #(.DEPTH(SB_DEPTH), .W(REQ_W)) u_fifo (
      .clk(clk), .rst(rst),
      .push(ctl.enqReq && selLarge == LARGE_W'(l)), .pushData(reqWord),
      .pop(deqPop[l]), .headValid(headValid[l]), .headData(headWord[l]),
      .full(fullVec[l])
    );
    assign headId[l]   = headWord[l][ID_LO +: ID_W];
    assign headPc[l]   = headWord[l][PC_LO +: PC_W];
    assign headSp[l]   = headWord[l][SP_LO +: SP_W];
    assign headCore[l] = headWord[l][0 +: CORE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneValid <= 1'b0;
      doneCore  <= '0;
      doneId    <= '0;
    end else begin
      doneValid <= ctl.retire;
      if (ctl.retire) begin
        doneCore <= retCore;
        doneId   <= retId;
      end
    end
  end
endmodule

// File: rtl/bcd_control.sv
module bcd_control
  import bcd_pkg::*;
#(
  parameter int NUM_SMALL = 4,
  parameter int CORE_W    = (NUM_SMALL > 1) ? $clog2(NUM_SMALL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stgValid,
  input  logic [CORE_W-1:0] stgCore,
  input  logic              lookHit,
  input  logic              selFull,
  input  logic              retValid,
  input  logic [CORE_W-1:0] retCore,
  output ctlStrobes_t       ctl
);
  logic [NUM_SMALL-1:0] inFlight;

  always_comb begin
    ctl.refuse   = stgValid && lookHit && (inFlight[stgCore] || selFull);
    ctl.enqReq   = stgValid && lookHit && !ctl.refuse;
    ctl.runLocal = stgValid && !ctl.enqReq;
    ctl.retire   = retValid && inFlight[retCore];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inFlight <= '0;
    end else begin
      if (ctl.enqReq) inFlight[stgCore] <= 1'b1;
      if (ctl.retire) inFlight[retCore] <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_dispatch_unit.sv
module bcd_dispatch_unit
  import bcd_pkg::*;
#(
  parameter int NUM_SMALL   = 4,
  parameter int NUM_LARGE   = 2,
  parameter int TABLE_DEPTH = 32,
  parameter int SB_DEPTH    = NUM_SMALL,
  parameter int ID_W        = 12,
  parameter int PC_W        = 16,
  parameter int SP_W        = 16,
  parameter int CORE_W      = (NUM_SMALL > 1) ? $clog2(NUM_SMALL) : 1,
  parameter int LARGE_W     = (NUM_LARGE > 1) ? $clog2(NUM_LARGE) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              updValid,
  input  logic [CORE_W-1:0]                 updCore,
  input  logic                              updAccel,
  input  logic [ID_W-1:0]                   updId,
  input  logic [LARGE_W-1:0]                updLarge,
  input  logic                              callValid,
  input  logic [CORE_W-1:0]                 callCore,
  input  logic [ID_W-1:0]                   callId,
  input  logic [PC_W-1:0]                   callPc,
  input  logic [SP_W-1:0]                   callSp,
  output logic                              localValid,
  output logic [CORE_W-1:0]                 localCore,
  output logic                              localBusy,
  output logic [NUM_LARGE-1:0]              headValid,
  output logic [NUM_LARGE-1:0][ID_W-1:0]    headId,
  output logic [NUM_LARGE-1:0][PC_W-1:0]    headPc,
  output logic [NUM_LARGE-1:0][SP_W-1:0]    headSp,
  output logic [NUM_LARGE-1:0][CORE_W-1:0]  headCore,
  input  logic [NUM_LARGE-1:0]              deqPop,
  input  logic                              retValid,
  input  logic [CORE_W-1:0]                 retCore,
  input  logic [ID_W-1:0]                   retId,
  output logic                              doneValid,
  output logic [CORE_W-1:0]                 doneCore,
  output logic [ID_W-1:0]                   doneId
);
  ctlStrobes_t       ctl;
  logic              stgValid, lookHit, selFull;
  logic [CORE_W-1:0] stgCore;

  bcd_control #(.NUM_SMALL(NUM_SMALL), .CORE_W(CORE_W)) u_ctrl (
    .clk(clk), .rst(rst), .stgValid(stgValid), .stgCore(stgCore),
    .lookHit(lookHit), .selFull(selFull), .retValid(retValid),
    .retCore(retCore), .ctl(ctl)
  );

  bcd_datapath #(
    .NUM_SMALL(NUM_SMALL), .NUM_LARGE(NUM_LARGE), .TABLE_DEPTH(TABLE_DEPTH),
    .SB_DEPTH(SB_DEPTH), .ID_W(ID_W), .PC_W(PC_W), .SP_W(SP_W),
    .CORE_W(CORE_W), .LARGE_W(LARGE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .updValid(updValid), .updCore(updCore), .updAccel(updAccel),
    .updId(updId), .updLarge(updLarge),
    .callValid(callValid), .callCore(callCore), .callId(callId),
    .callPc(callPc), .callSp(callSp),
    .deqPop(deqPop), .retCore(retCore), .retId(retId),
    .stgValid(stgValid), .stgCore(stgCore), .lookHit(lookHit), .selFull(selFull),
    .headValid(headValid), .headId(headId), .headPc(headPc), .headSp(headSp),
    .headCore(headCore), .doneValid(doneValid), .doneCore(doneCore), .doneId(doneId)
  );

  assign localValid = ctl.runLocal;
  assign localBusy  = ctl.refuse;
  assign localCore  = stgCore;
endmodule

// File: rtl/bcd_dispatch_checker.sv
module bcd_dispatch_checker #(
  parameter int NUM_LARGE = 2,
  parameter int ID_W      = 12
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           callValid,
  input logic                           localValid,
  input logic                           localBusy,
  input logic                           enqReq,
  input logic                           retValid,
  input logic                           doneValid,
  input logic [NUM_LARGE-1:0]           headValid,
  input logic [NUM_LARGE-1:0][ID_W-1:0] headId,
  input logic [NUM_LARGE-1:0]           deqPop
);
  // a refusal is always delivered as a local verdict
  p_busy_is_local_r7: assert property (@(posedge clk) disable iff (rst)
    localBusy |-> localValid);

  // a shipped call never also runs locally
  p_ship_not_local_r3: assert property (@(posedge clk) disable iff (rst)
    !(enqReq && localValid));

  // a local verdict answers a call made one cycle earlier
  p_local_follows_call_r2: assert property (@(posedge clk) disable iff (rst)
    localValid |-> $past(callValid));

  // completion only follows a return
  p_done_after_return_r8: assert property (@(posedge clk) disable iff (rst)
    doneValid |-> $past(retValid));

  for (genvar l = 0; l < NUM_LARGE; l++) begin : g_hold
    // head stays put until popped
    p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (headValid[l] && !deqPop[l]) |=> (headValid[l] && $stable(headId[l])));
  end
endmodule

bind bcd_dispatch_unit bcd_dispatch_checker #(.NUM_LARGE(NUM_LARGE), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .callValid(callValid), .localValid(localValid),
  .localBusy(localBusy), .enqReq(ctl.enqReq), .retValid(retValid),
  .doneValid(doneValid), .headValid(headValid), .headId(headId), .deqPop(deqPop)
);

// File: tb/bcd_dispatch_unit_test.sv
module bcd_dispatch_unit_test;
  localparam int NS = 4, NL = 2, TD = 32, IDW = 12, PCW = 16, SPW = 16, CW = 2, LW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic updValid = 0, updAccel = 0, callValid = 0, retValid = 0;
  logic [CW-1:0] updCore = 0, callCore = 0, retCore = 0;
  logic [IDW-1:0] updId = 0, callId = 0, retId = 0;
  logic [LW-1:0] updLarge = 0;
  logic [PCW-1:0] callPc = 0;
  logic [SPW-1:0] callSp = 0;
  logic [NL-1:0] deqPop = 0;
  logic localValid, localBusy, doneValid;
  logic [CW-1:0] localCore, doneCore;
  logic [IDW-1:0] doneId;
  logic [NL-1:0] headValid;
  logic [NL-1:0][IDW-1:0] headId;
  logic [NL-1:0][PCW-1:0] headPc;
  logic [NL-1:0][SPW-1:0] headSp;
  logic [NL-1:0][CW-1:0] headCore;

  bcd_dispatch_unit uut (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  // reference model
  int mId [NS][TD];
  int mLg [NS][TD];
  int mCnt [NS];
  bit mOut [NS];
  int qId [NL][8], qPc [NL][8], qSp [NL][8], qCore [NL][8];
  int qCnt [NL];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mFind(input int s, input int id);
    for (int k = 0; k < mCnt[s]; k++) if (mId[s][k] == id) return k;
    return -1;
  endfunction

  function automatic void mRemoveAt(input int s, input int k);
    for (int j = k; j < mCnt[s] - 1; j++) begin
      mId[s][j] = mId[s][j+1];
      mLg[s][j] = mLg[s][j+1];
    end
    mCnt[s]--;
  endfunction

  function automatic void mAccel(input int s, input int id, input int lg);
    int k = mFind(s, id);
    if (k >= 0) mRemoveAt(s, k);
    else if (mCnt[s] == TD) mCnt[s]--;          // drop the oldest (last)
    for (int j = mCnt[s]; j > 0; j--) begin
      mId[s][j] = mId[s][j-1];
      mLg[s][j] = mLg[s][j-1];
    end
    mId[s][0] = id;
    mLg[s][0] = lg;
    mCnt[s]++;
  endfunction

  task automatic checkHeads(input string tag);
    for (int l = 0; l < NL; l++) begin
      chk($sformatf("%s head valid L%0d", tag, l), headValid[l], qCnt[l] > 0);
      if (qCnt[l] > 0) begin
        chk($sformatf("%s head id L%0d", tag, l), headId[l], qId[l][0]);
        chk($sformatf("%s head pc L%0d", tag, l), headPc[l], qPc[l][0]);
        chk($sformatf("%s head sp L%0d", tag, l), headSp[l], qSp[l][0]);
        chk($sformatf("%s head core L%0d", tag, l), headCore[l], qCore[l][0]);
      end
    end
  endtask

  task automatic doUpd(input int s, input bit acc, input int id, input int lg);
    @(negedge clk);
    updValid = 1; updCore = CW'(s); updAccel = acc; updId = IDW'(id); updLarge = LW'(lg);
    @(negedge clk);
    updValid = 0;
    if (acc) mAccel(s, id, lg);
    else if (mFind(s, id) >= 0) mRemoveAt(s, mFind(s, id));
  endtask

  task automatic doCall(input string tag, input int s, input int id, input int pc, input int sp);
    int k, lg;
    bit hit, ship;
    @(negedge clk);
    callValid = 1; callCore = CW'(s); callId = IDW'(id); callPc = PCW'(pc); callSp = SPW'(sp);
    k = mFind(s, id);
    hit = (k >= 0);
    lg = hit ? mLg[s][k] : 0;
    ship = hit && !mOut[s] && qCnt[lg] < NS;
    @(negedge clk);
    callValid = 0;
    chk($sformatf("%s R2 local valid", tag), localValid, !ship);
    chk($sformatf("%s R7 busy", tag), localBusy, hit && !ship);
    if (!ship) chk($sformatf("%s R2 local core", tag), localCore, s);
    if (ship) begin
      qId[lg][qCnt[lg]] = id; qPc[lg][qCnt[lg]] = pc;
      qSp[lg][qCnt[lg]] = sp; qCore[lg][qCnt[lg]] = s;
      qCnt[lg]++;
      mOut[s] = 1;
    end
    @(negedge clk);
    checkHeads($sformatf("%s R3", tag));
  endtask

  task automatic doPop(input string tag, input int l);
    @(negedge clk);
    deqPop = NL'(1) << l;
    @(negedge clk);
    deqPop = 0;
    if (qCnt[l] > 0) begin
      for (int j = 0; j < qCnt[l] - 1; j++) begin
        qId[l][j] = qId[l][j+1]; qPc[l][j] = qPc[l][j+1];
        qSp[l][j] = qSp[l][j+1]; qCore[l][j] = qCore[l][j+1];
      end
      qCnt[l]--;
    end
    checkHeads(tag);
  endtask

  task automatic doRet(input string tag, input int s, input int id);
    bit exp;
    @(negedge clk);
    retValid = 1; retCore = CW'(s); retId = IDW'(id);
    exp = mOut[s];
    @(negedge clk);
    retValid = 0;
    chk($sformatf("%s R8 done valid", tag), doneValid, exp);
    if (exp) begin
      chk($sformatf("%s R8 done core", tag), doneCore, s);
      chk($sformatf("%s R8 done id", tag), doneId, id);
    end
    mOut[s] = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20811));
    for (int s = 0; s < NS; s++) begin mCnt[s] = 0; mOut[s] = 0; end
    for (int l = 0; l < NL; l++) qCnt[l] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset heads", headValid, 0);
    chk("R1 reset local", localValid, 0);
    chk("R1 reset done", doneValid, 0);
    doCall("R1 empty table", 0, 5, 16'h100, 16'h200);

    // R2 miss, R3 hit and ship, R7 in-flight refusal, R8 completion
    doCall("R2 miss", 1, 7, 16'h111, 16'h222);
    doUpd(1, 1, 7, 1);
    doCall("R3 hit", 1, 7, 16'h333, 16'h444);
    doCall("R7 second in flight", 1, 7, 16'h555, 16'h666);
    doRet("R8 idle core", 2, 9);
    doRet("R8 return", 1, 7);
    doCall("R8 ship again", 1, 7, 16'h777, 16'h888);
    // R4 repoint, removal, independence of tables
    doUpd(1, 1, 7, 0);
    doRet("R8 free", 1, 7);
    doCall("R4 repointed", 1, 7, 16'h999, 16'haaa);
    doCall("R4 other core miss", 2, 7, 16'h1, 16'h2);
    doUpd(1, 0, 7, 0);
    doUpd(1, 0, 300, 0);
    doRet("R4 free", 1, 7);
    doCall("R4 removed", 1, 7, 16'h3, 16'h4);
    // R6 order: two cores into large core 1
    doUpd(2, 1, 20, 1);
    doUpd(3, 1, 21, 1);
    doCall("R6 first", 2, 20, 16'h20, 16'h20);
    doCall("R6 second", 3, 21, 16'h21, 16'h21);
    doPop("R6 pop", 1);
    doPop("R6 pop", 1);
    doPop("R6 pop", 1);
    doPop("R9 pop empty", 1);
    doPop("R9 pop empty", 0);
    doPop("R9 pop empty", 0);
    doRet("R6 free", 2, 20);
    doRet("R6 free", 3, 21);
    doCall("R9 after empty pops", 2, 20, 16'h55, 16'h66);
    doPop("R9 drain", 1);
    doRet("R9 free", 2, 20);
    // R5 eviction in a full table of core 3
    for (int i = 0; i < TD; i++) doUpd(3, 1, 100 + i, i % NL);
    doUpd(3, 1, 100, 0);           // refresh the oldest
    doUpd(3, 1, 200, 1);           // evicts 101
    doCall("R5 victim gone", 3, 101, 16'h5, 16'h6);
    doCall("R5 refreshed kept", 3, 100, 16'h7, 16'h8);
    doPop("R5 drain", 0);
    doRet("R5 free", 3, 100);
    doCall("R5 new kept", 3, 200, 16'h9, 16'ha);
    doPop("R5 drain", 1);
    doRet("R5 free", 3, 200);
    doCall("R5 neighbour kept", 3, 102, 16'hb, 16'hc);

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      int op = $urandom_range(0, 9);
      int s = $urandom_range(0, NS - 1);
      int id = $urandom_range(0, 39);
      if (op <= 2) doUpd(s, $urandom_range(0, 3) != 0, id, $urandom_range(0, NL - 1));
      else if (op <= 5) doCall("R3 random", s, id, $urandom_range(0, 65535), $urandom_range(0, 65535));
      else if (op <= 7) doPop("R6 random", $urandom_range(0, NL - 1));
      else doRet("R8 random", s, id);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule